// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is one bank of general-purpose I/O lines. The bank holds several small ports of eight pins each. Software reaches it through a simple 32-bit word bus. For each port it can set a configuration word, output-enable bits, output levels and interrupt enables. It can also choose a trigger mode per pin, read the synchronised input levels, read which pins have raised an event, and acknowledge events.

Every input pin passes through a synchroniser. After that, a detector compares the pin's current value with its value one clock earlier. Depending on three mode bits, the detector responds to a steady level, to a single edge direction, or to any change. Each detected event latches a status bit. The status bits, masked by the enables of all ports, combine into one interrupt line for the whole bank.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is low and just after it is released, every register is zero: `bus_rdata`, `cfg_out`, `oe_out`, `dout_out` and `irq` all read 0.
- R2: The configuration (group 0), output-enable (group 1), output-data (group 2) and interrupt-enable (group 5) registers read back the low 8 bits last written to them. The trigger-mode register (group 6) reads back bits [23:0]. The configuration, output-enable and output-data values of port p appear on bits [8p+7:8p] of `cfg_out`, `oe_out` and `dout_out`.
- R3: A read of group 3 returns the pin levels of the port after they pass through the two-flop synchroniser. Writes to group 3 are ignored. For every read, `bus_rdata` is updated on the clock edge that samples the read strobe and holds until the next read.
- R4: When a pin has trigger-mode bit n+8 = 0 and bit n+16 = 0, its status bit sets on every cycle in which the pin equals polarity bit n. A status bit cleared while that level is still present sets again.
- R5: When a pin has bit n+8 = 1 and bit n+16 = 0, it reacts only to a rising edge if bit n = 1, or only to a falling edge if bit n = 0.
- R6: When bit n+16 = 1, the pin reacts to both rising and falling edges. This applies whatever the values of the polarity bit and the edge bit.
- R7: Writing a 1 to bit n of the clear register (group 7) clears status bit n. A 0 bit leaves status unchanged. If an event and a clear hit the same bit in the same cycle, the event wins. Status bits change only through events and clears.
- R8: A status bit sets even when its enable bit is 0. `irq` is high exactly when some port has a status bit and its matching enable bit both set.
- R9: Word address bits [6:4] select the register group and bits [3:2] select the port. Addresses with bit 7 set are unmapped: they read as zero and ignore writes. Group 4 (status) ignores writes. Group 7 (clear) reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the word within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels, port p on bits [8p+7:8p] |
| cfg_out | output | 32 | Configuration bits of all ports |
| oe_out | output | 32 | Output-enable bits of all ports |
| dout_out | output | 32 | Output levels of all ports |
| irq | output | 1 | Bank interrupt |

## Verification
A register write takes effect on the edge that samples it, so its output is visible at the next falling edge. Read data arrives one edge after the read strobe. A change on a pin reaches the status bit and `irq` three edges later: two synchroniser flops, then the status register. The bench therefore waits four cycles after each pin change before it reads status. It issues reads with a one-cycle strobe and samples `bus_rdata` at the falling edge after the strobe. The same-cycle case of a clear and an event is driven with the level still present, so the clear and the event are certain to land on the same edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Register group selected by word address bits [6:4]
   typedef enum logic [2:0] {
      GRP_CFG  = 3'd0,
      GRP_OE   = 3'd1,
      GRP_DOUT = 3'd2,
      GRP_IN   = 3'd3,
      GRP_STAT = 3'd4,
      GRP_IEN  = 3'd5,
      GRP_LVL  = 3'd6,
      GRP_CLR  = 3'd7
   } grp_e;

   // Spacing of the polarity / edge / both-edge fields in the trigger-mode word
   localparam int unsigned LVL_FIELD = 8;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned MAX_PORTS = 4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned PINS = 8
) (
   input  logic [PINS-1:0] cur,
   input  logic [PINS-1:0] prev,
   input  logic [PINS-1:0] pol,
   input  logic [PINS-1:0] edg,
   input  logic [PINS-1:0] both,
   output logic [PINS-1:0] evt
);

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic rise, fall, edge_hit, level_hit;
      assign rise      = cur[i] & ~prev[i];
      assign fall      = ~cur[i] & prev[i];
      assign edge_hit  = pol[i] ? rise : fall;
      assign level_hit = (cur[i] == pol[i]);
      // both-edge mode outranks the polarity and edge/level choice
      assign evt[i] = both[i] ? (rise | fall) :
                      edg[i]  ? edge_hit : level_hit;
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  grp_e             grp,
   input  logic [BUS_W-1:0] wdata,
   input  logic [PINS-1:0]  cur,
   output logic [PINS-1:0]  cfg,
   output logic [PINS-1:0]  oe,
   output logic [PINS-1:0]  dout,
   output logic [PINS-1:0]  ien,
   output logic [PINS-1:0]  status,
   output logic [BUS_W-1:0] rd_word
);

   logic [PINS-1:0] pol_q, edg_q, both_q;
   logic [PINS-1:0] prev_q;
   logic [PINS-1:0] evt;
   logic [PINS-1:0] clr_mask;

   gpio_irq_detect #(.PINS(PINS)) i_detect (
      .cur  (cur),
      .prev (prev_q),
      .pol  (pol_q),
      .edg  (edg_q),
      .both (both_q),
      .evt  (evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         oe     <= '0;
         dout   <= '0;
         ien    <= '0;
         pol_q  <= '0;
         edg_q  <= '0;
         both_q <= '0;
      end else if (wr_stb) begin
         case (grp)
            GRP_CFG:  cfg  <= wdata[PINS-1:0];
            GRP_OE:   oe   <= wdata[PINS-1:0];
            GRP_DOUT: dout <= wdata[PINS-1:0];
            GRP_IEN:  ien  <= wdata[PINS-1:0];
            GRP_LVL: begin
               pol_q  <= wdata[0*LVL_FIELD +: PINS];
               edg_q  <= wdata[1*LVL_FIELD +: PINS];
               both_q <= wdata[2*LVL_FIELD +: PINS];
            end
            default: ;
         endcase
      end
   end

   assign clr_mask = (wr_stb && grp == GRP_CLR) ? wdata[PINS-1:0] : '0;

   // history for edge detection, and sticky status with event priority
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= cur;
         status <= (status & ~clr_mask) | evt;
      end
   end

   always_comb begin
      rd_word = '0;
      case (grp)
         GRP_CFG:  rd_word[PINS-1:0] = cfg;
         GRP_OE:   rd_word[PINS-1:0] = oe;
         GRP_DOUT: rd_word[PINS-1:0] = dout;
         GRP_IN:   rd_word[PINS-1:0] = cur;
         GRP_STAT: rd_word[PINS-1:0] = status;
         GRP_IEN:  rd_word[PINS-1:0] = ien;
         GRP_LVL: begin
            rd_word[0*LVL_FIELD +: PINS] = pol_q;
            rd_word[1*LVL_FIELD +: PINS] = edg_q;
            rd_word[2*LVL_FIELD +: PINS] = both_q;
         end
         default:  rd_word = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned PINS        = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned TOTAL      = NUM_PORTS * PINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [TOTAL-1:0]  pin_in,
   output logic [TOTAL-1:0]  cfg_out,
   output logic [TOTAL-1:0]  oe_out,
   output logic [TOTAL-1:0]  dout_out,
   output logic              irq
);

   if (PINS < 1 || PINS > LVL_FIELD) begin : g_bad_pins
      $error("gpio_irq_bank: PINS must be 1..8");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("gpio_irq_bank: NUM_PORTS must be 1..4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must be at least 8");
   end

   logic [TOTAL-1:0] pin_sync;
   logic [TOTAL-1:0] status_all;
   logic [TOTAL-1:0] ien_all;
   logic [BUS_W-1:0] rd_words [MAX_PORTS];
   logic [1:0]       port_idx;
   logic             mapped;
   logic             port_ok;
   grp_e             grp;

   assign port_idx = bus_addr[3:2];
   assign mapped   = (bus_addr[ADDR_W-1:7] == '0);
   assign port_ok  = (32'(port_idx) < NUM_PORTS);
   assign grp      = grp_e'(bus_addr[6:4]);

   gpio_sync #(.W(TOTAL), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
      if (p < NUM_PORTS) begin : g_live
         logic wr_stb;
         assign wr_stb = bus_sel && bus_we && mapped && (port_idx == 2'(p));
         gpio_port #(.PINS(PINS)) i_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_stb),
            .grp     (grp),
            .wdata   (bus_wdata),
            .cur     (pin_sync[p*PINS +: PINS]),
            .cfg     (cfg_out[p*PINS +: PINS]),
            .oe      (oe_out[p*PINS +: PINS]),
            .dout    (dout_out[p*PINS +: PINS]),
            .ien     (ien_all[p*PINS +: PINS]),
            .status  (status_all[p*PINS +: PINS]),
            .rd_word (rd_words[p])
         );
      end else begin : g_absent
         assign rd_words[p] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_sel && !bus_we) begin
         bus_rdata <= (mapped && port_ok) ? rd_words[port_idx] : '0;
      end
   end

   assign irq = |(status_all & ien_all);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned PINS      = 8,
   parameter int unsigned ADDR_W    = 8,
   localparam int unsigned TOTAL    = NUM_PORTS * PINS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [TOTAL-1:0]  cfg_out,
   input logic [TOTAL-1:0]  oe_out,
   input logic [TOTAL-1:0]  dout_out,
   input logic              irq,
   input logic [TOTAL-1:0]  status_all,
   input logic [TOTAL-1:0]  ien_all
);

   logic rd_stb, wr_stb, clr0_bit0;
   assign rd_stb    = bus_sel && !bus_we;
   assign wr_stb    = bus_sel && bus_we;
   assign clr0_bit0 = wr_stb && bus_addr[ADDR_W-1:4] == '0 + 7 && bus_addr[3:2] == 2'd0
                      && bus_wdata[0];

   p_unmapped_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && bus_addr[ADDR_W-1:7] != '0 |=> bus_rdata == '0);

   p_rdata_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(bus_rdata));

   p_cfg_write_port0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && bus_addr[ADDR_W-1:4] == '0 && bus_addr[3:2] == 2'd0
      |=> cfg_out[PINS-1:0] == $past(bus_wdata[PINS-1:0]));

   p_outputs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(cfg_out) && $stable(oe_out) && $stable(dout_out));

   p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ien_all == '0 |-> !irq);

   p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_all[0] && !clr0_bit0 |=> status_all[0]);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PINS      (PINS),
   .ADDR_W    (ADDR_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .cfg_out    (cfg_out),
   .oe_out     (oe_out),
   .dout_out   (dout_out),
   .irq        (irq),
   .status_all (status_all),
   .ien_all    (ien_all)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] cfg_out, oe_out, dout_out;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_bank i_gpio_irq_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .cfg_out   (cfg_out),
      .oe_out    (oe_out),
      .dout_out  (dout_out),
      .irq       (irq)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  addr;
      logic [31:0] data;   // write data, or expected read value
   } vec_t;

   localparam int NVEC = 15;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 8'h00, 32'h0000_00A5},
      '{1'b1, 8'h14, 32'h0000_003C},
      '{1'b1, 8'h28, 32'h0000_005A},
      '{1'b1, 8'h6C, 32'h0012_3456},
      '{1'b1, 8'h0C, 32'hFFFF_FF77},
      '{1'b1, 8'h84, 32'hFFFF_FFFF},
      '{1'b0, 8'h00, 32'h0000_00A5},
      '{1'b0, 8'h14, 32'h0000_003C},
      '{1'b0, 8'h28, 32'h0000_005A},
      '{1'b0, 8'h6C, 32'h0012_3456},
      '{1'b0, 8'h0C, 32'h0000_0077},
      '{1'b0, 8'h84, 32'h0000_0000},
      '{1'b0, 8'h04, 32'h0000_0000},
      '{1'b0, 8'h70, 32'h0000_0000},
      '{1'b0, 8'hF0, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      idle(3);
      chk("R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cfg_out", cfg_out, 32'h0);
      chk("R1 oe_out", oe_out, 32'h0);
      chk("R1 dout_out", dout_out, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R2 / R9 table walk
      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, r);
            chk("R2/R9 table read", r, VEC[i].data);
         end
      end
      chk("R2 cfg_out lanes", cfg_out, 32'h7700_00A5);
      chk("R2 oe_out lanes", oe_out, 32'h0000_3C00);
      chk("R2 dout_out lanes", dout_out, 32'h005A_0000);

      // R8: port 2 pins sit low in default active-low level mode
      idle(4);
      chk("R8 irq off while disabled", {31'h0, irq}, 32'h0);
      wr(8'h58, 32'h10);
      chk("R8 irq from port 2", {31'h0, irq}, 32'h1);
      wr(8'h58, 32'h00);
      chk("R8 irq drops with enable", {31'h0, irq}, 32'h0);

      // R3: synchronised input readback
      pin_in = 32'hA53C_0F81;
      idle(4);
      rd(8'h30, r); chk("R3 input port0", r, 32'h81);
      rd(8'h34, r); chk("R3 input port1", r, 32'h0F);
      rd(8'h3C, r); chk("R3 input port3", r, 32'hA5);
      wr(8'h30, 32'hFF);
      rd(8'h30, r); chk("R3 input write ignored", r, 32'h81);
      pin_in = '0;
      idle(4);

      // port 0: all edge mode, pin0 rising, others falling
      wr(8'h60, 32'h0000_FF01);
      idle(4);
      wr(8'h70, 32'hFF);
      idle(2);
      rd(8'h40, r); chk("R7 status cleared", r, 32'h0);
      wr(8'h40, 32'hFF);
      rd(8'h40, r); chk("R9 status write ignored", r, 32'h0);

      pin_in[0] = 1'b1;
      idle(4);
      rd(8'h40, r); chk("R8 status sets while disabled", r, 32'h01);
      chk("R8 irq off", {31'h0, irq}, 32'h0);
      wr(8'h50, 32'h01);
      chk("R8 irq on", {31'h0, irq}, 32'h1);
      wr(8'h70, 32'h00);
      rd(8'h40, r); chk("R7 zero clear no effect", r, 32'h01);
      wr(8'h70, 32'h01);
      rd(8'h40, r); chk("R7 clear", r, 32'h00);
      chk("R7 irq after clear", {31'h0, irq}, 32'h0);

      // R5 edge direction
      pin_in[0] = 1'b0;
      idle(4);
      rd(8'h40, r); chk("R5 falling ignored on rising pin", r, 32'h00);
      pin_in[1] = 1'b1;
      idle(4);
      rd(8'h40, r); chk("R5 rising ignored on falling pin", r, 32'h00);
      pin_in[1] = 1'b0;
      idle(4);
      rd(8'h40, r); chk("R5 falling caught", r, 32'h02);
      wr(8'h70, 32'h02);

      // R6 both edges on pin2 (polarity 0, edge bit 1)
      wr(8'h60, 32'h0004_FF01);
      pin_in[2] = 1'b1;
      idle(4);
      rd(8'h40, r); chk("R6 rising caught", r, 32'h04);
      wr(8'h70, 32'h04);
      pin_in[2] = 1'b0;
      idle(4);
      rd(8'h40, r); chk("R6 falling caught", r, 32'h04);
      wr(8'h70, 32'h04);

      // R4 level-high on pin3
      wr(8'h60, 32'h0004_F709);
      idle(4);
      rd(8'h40, r); chk("R4 inactive level", r, 32'h00);
      pin_in[3] = 1'b1;
      idle(4);
      rd(8'h40, r); chk("R4 active level", r, 32'h08);
      wr(8'h70, 32'h08);
      rd(8'h40, r); chk("R4 R7 event beats clear", r, 32'h08);
      pin_in[3] = 1'b0;
      idle(4);
      wr(8'h70, 32'h08);
      idle(2);
      rd(8'h40, r); chk("R4 clears once level gone", r, 32'h00);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule